// File: doc/BRIEF.md
# Macro Call Parameter Collector

This block sits in front of a command-driven register file. Method writes whose index falls in the reserved macro range are not register writes. They invoke macros that were uploaded earlier. Each uploaded macro occupies an entry of a small code table, which records the macro's base address and length in a shared instruction RAM. Entry E answers to method index `MACRO_BASE + 2*E`, with `MACRO_BASE` defaulting to 0xE00.

A call is a stream of method writes. The first macro-range write after idle opens the call and selects the target entry. Every write of the call, the first included, appends its 32-bit value to a parameter buffer. The call fires on the write whose remaining-parameter count is zero. If the target has code, the block pulses `start`, presents the entry's base and length, and becomes busy until the executor returns `exec_done`. While busy, the executor sees the first parameter on its own port and can pop the remaining words one by one. If the target has no code, the block raises a sticky error instead and returns to idle.

Top module: `macro_collector`

## Requirements
- R1: After reset `start`, `busy`, `err_missing` and `err_overflow` are 0 and `fetch_empty` is 1.
- R2: A method write whose index is below `MACRO_BASE` has no effect: no call opens, no start occurs, no error is raised.
- R3: An upload of entry E stores a base and a length. A call to method `MACRO_BASE + 2*E` starts with `start_base` and `start_len` equal to entry E's stored values, and both are valid in the cycle where `start` is high.
- R4: Every accepted macro-range write appends its value to the call. The call fires on the write that carries a remaining count of 0. `start` is high for exactly one cycle, the cycle after that write.
- R5: From the start cycle until done, `first_param` holds the first word of the call and `param_count` holds the number of stored words.
- R6: While busy, `fetch_data` shows the stored words from the second word onward, in arrival order. Each `fetch_pop` advances to the next word. `fetch_empty` is 1 once all the words are consumed, and a pop while empty changes nothing.
- R7: `busy` rises together with `start` and falls in the cycle after `exec_done`. Macro writes that arrive while busy are ignored, and `param_count` holds steady.
- R8: A call that fires on an odd offset from `MACRO_BASE`, on an entry at or beyond `ENTRIES`, or on an entry that was never uploaded produces no start. It sets the sticky flag `err_missing` one cycle later and leaves the block idle.
- R9: A call stores at most `DEPTH` (16) words. Any further word is dropped and sets the sticky flag `err_overflow`. The call still fires with `DEPTH` words.
- R10: Uploading an entry again replaces its base and length for every later call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mth_valid | input | 1 | Method write strobe |
| mth_index | input | METHOD_W | Method index |
| mth_data | input | DATA_W | Method value |
| mth_remaining | input | REM_W | Parameters still to come after this write |
| upl_valid | input | 1 | Code table write strobe |
| upl_entry | input | ENTRY_W | Entry being uploaded |
| upl_base | input | ADDR_W | Base address of the entry's code |
| upl_len | input | ADDR_W | Length of the entry's code |
| fetch_pop | input | 1 | Consume the word on `fetch_data` |
| exec_done | input | 1 | Executor has finished the call |
| start | output | 1 | One-cycle execution request |
| busy | output | 1 | A call is with the executor |
| start_base | output | ADDR_W | Code base of the started call |
| start_len | output | ADDR_W | Code length of the started call |
| first_param | output | DATA_W | First parameter word |
| param_count | output | CNT_W | Stored parameter words |
| fetch_data | output | DATA_W | Next queued parameter |
| fetch_empty | output | 1 | No queued parameter remains |
| err_missing | output | 1 | Sticky: a call fired without code |
| err_overflow | output | 1 | Sticky: parameter words were dropped |

## Verification
Every result is registered on the same edge that samples the final write, `exec_done` or a pop. So `start`, `busy`, the start base and length, the parameter outputs and both error flags are all due one cycle after their stimulus. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares every output on the next falling edge, which is exactly one register stage after the stimulus. The parameter and queue outputs are compared only while the model is busy, because they carry no meaning at other times.

// File: rtl/macro_coll_pkg.sv
package macro_coll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_BUSY    = 2'd2
  } coll_state_e;

  // Index lies in the reserved macro range.
  function automatic logic in_macro_range(input int unsigned idx, input int unsigned base);
    return idx >= base;
  endfunction

  // Entry number addressed by a macro method (two methods per entry).
  function automatic int unsigned entry_of(input int unsigned idx, input int unsigned base);
    return (idx - base) >> 1;
  endfunction

  // Method index is exactly the binding point of an existing entry.
  function automatic logic is_bound(input int unsigned idx, input int unsigned base,
                                    input int unsigned entries);
    int unsigned off;
    off = idx - base;
    return (idx >= base) && (off[0] == 1'b0) && ((off >> 1) < entries);
  endfunction

endpackage

// File: rtl/mc_code_table.sv
module mc_code_table #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 10,
  localparam int ENTRY_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic [ADDR_W-1:0]  wr_base,
  input  logic [ADDR_W-1:0]  wr_len,
  input  logic [ENTRY_W-1:0] rd_entry,
  output logic               rd_valid,
  output logic [ADDR_W-1:0]  rd_base,
  output logic [ADDR_W-1:0]  rd_len
);

  logic [ENTRIES-1:0] ent_valid;
  logic [ADDR_W-1:0]  ent_base [ENTRIES];
  logic [ADDR_W-1:0]  ent_len  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[e] <= 1'b0;
        ent_base[e]  <= '0;
        ent_len[e]   <= '0;
      end else if (wr_en && (wr_entry == ENTRY_W'(e))) begin
        ent_valid[e] <= 1'b1;
        ent_base[e]  <= wr_base;
        ent_len[e]   <= wr_len;
      end
    end
  end

  assign rd_valid = ent_valid[rd_entry];
  assign rd_base  = ent_base[rd_entry];
  assign rd_len   = ent_len[rd_entry];

endmodule

// File: rtl/mc_param_buf.sv
module mc_param_buf #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_push,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] first_word,
  output logic [DATA_W-1:0] head_word,
  output logic              empty,
  output logic              ovf_evt,
  output logic              ovf_flag
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  rd_ptr;
  logic              full;

  assign full    = count == CNT_W'(DEPTH);
  assign empty   = rd_ptr >= count;
  assign ovf_evt = push && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      rd_ptr   <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (clear_push) begin
        count  <= CNT_W'(1);
        rd_ptr <= CNT_W'(1);
      end else begin
        if (push && !full) count <= count + CNT_W'(1);
        if (pop && !empty) rd_ptr <= rd_ptr + CNT_W'(1);
      end
      if (ovf_evt) ovf_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clear_push) mem[0] <= push_data;
    else if (push && !full) mem[count[IDX_W-1:0]] <= push_data;
  end

  assign first_word = mem[0];
  assign head_word  = (rd_ptr < CNT_W'(DEPTH)) ? mem[rd_ptr[IDX_W-1:0]] : '0;

endmodule

// File: rtl/mc_call_ctrl.sv
module mc_call_ctrl
  import macro_coll_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 10,
  localparam int ENTRY_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic               wr_last,
  input  logic               wr_bound,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               exec_done,
  input  logic               tbl_valid,
  input  logic [ADDR_W-1:0]  tbl_base,
  input  logic [ADDR_W-1:0]  tbl_len,
  output logic [ENTRY_W-1:0] tbl_rd_entry,
  output logic               buf_clear_push,
  output logic               buf_push,
  output logic               start,
  output logic               busy,
  output logic [ADDR_W-1:0]  start_base,
  output logic [ADDR_W-1:0]  start_len,
  output logic               err_missing,
  output logic               fire_evt,
  output logic               miss_evt
);

  coll_state_e        state;
  logic               held_bound;
  logic [ENTRY_W-1:0] held_entry;
  logic               accept, first, sel_bound, fire_ok;

  assign accept         = wr_valid && (state != ST_BUSY);
  assign first          = accept && (state == ST_IDLE);
  assign buf_clear_push = first;
  assign buf_push       = accept && (state == ST_COLLECT);
  assign sel_bound      = first ? wr_bound : held_bound;
  assign tbl_rd_entry   = first ? wr_entry : held_entry;
  assign fire_evt       = accept && wr_last;
  assign fire_ok        = fire_evt && sel_bound && tbl_valid;
  assign miss_evt       = fire_evt && !fire_ok;
  assign busy           = state == ST_BUSY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      held_bound  <= 1'b0;
      held_entry  <= '0;
      start       <= 1'b0;
      start_base  <= '0;
      start_len   <= '0;
      err_missing <= 1'b0;
    end else begin
      start <= fire_ok;
      if (first) begin
        held_bound <= wr_bound;
        held_entry <= wr_entry;
      end
      if (fire_ok) begin
        start_base <= tbl_base;
        start_len  <= tbl_len;
      end
      if (miss_evt) err_missing <= 1'b1;
      unique case (state)
        ST_IDLE, ST_COLLECT: begin
          if (fire_ok)       state <= ST_BUSY;
          else if (fire_evt) state <= ST_IDLE;
          else if (accept)   state <= ST_COLLECT;
        end
        ST_BUSY: if (exec_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/macro_collector.sv
module macro_collector
  import macro_coll_pkg::*;
#(
  parameter int METHOD_W = 12,
  parameter int DATA_W   = 32,
  parameter int REM_W    = 8,
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 10,
  parameter int DEPTH    = 16,
  parameter logic [METHOD_W-1:0] MACRO_BASE = 12'hE00,
  localparam int ENTRY_W = $clog2(ENTRIES),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mth_valid,
  input  logic [METHOD_W-1:0] mth_index,
  input  logic [DATA_W-1:0]   mth_data,
  input  logic [REM_W-1:0]    mth_remaining,
  input  logic                upl_valid,
  input  logic [ENTRY_W-1:0]  upl_entry,
  input  logic [ADDR_W-1:0]   upl_base,
  input  logic [ADDR_W-1:0]   upl_len,
  input  logic                fetch_pop,
  input  logic                exec_done,
  output logic                start,
  output logic                busy,
  output logic [ADDR_W-1:0]   start_base,
  output logic [ADDR_W-1:0]   start_len,
  output logic [DATA_W-1:0]   first_param,
  output logic [CNT_W-1:0]    param_count,
  output logic [DATA_W-1:0]   fetch_data,
  output logic                fetch_empty,
  output logic                err_missing,
  output logic                err_overflow
);

  logic               macro_wr, wr_last, wr_bound;
  logic [ENTRY_W-1:0] wr_entry, tbl_rd_entry;
  logic               tbl_valid;
  logic [ADDR_W-1:0]  tbl_base, tbl_len;
  logic               buf_clear_push, buf_push;
  logic               fire_evt, miss_evt, ovf_evt;

  assign macro_wr = mth_valid && in_macro_range(32'(mth_index), 32'(MACRO_BASE));
  assign wr_last  = mth_remaining == '0;
  assign wr_bound = is_bound(32'(mth_index), 32'(MACRO_BASE), ENTRIES);
  assign wr_entry = ENTRY_W'(entry_of(32'(mth_index), 32'(MACRO_BASE)));

  mc_code_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (upl_valid),
    .wr_entry (upl_entry),
    .wr_base  (upl_base),
    .wr_len   (upl_len),
    .rd_entry (tbl_rd_entry),
    .rd_valid (tbl_valid),
    .rd_base  (tbl_base),
    .rd_len   (tbl_len)
  );

  mc_call_ctrl #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (macro_wr),
    .wr_last        (wr_last),
    .wr_bound       (wr_bound),
    .wr_entry       (wr_entry),
    .exec_done      (exec_done),
    .tbl_valid      (tbl_valid),
    .tbl_base       (tbl_base),
    .tbl_len        (tbl_len),
    .tbl_rd_entry   (tbl_rd_entry),
    .buf_clear_push (buf_clear_push),
    .buf_push       (buf_push),
    .start          (start),
    .busy           (busy),
    .start_base     (start_base),
    .start_len      (start_len),
    .err_missing    (err_missing),
    .fire_evt       (fire_evt),
    .miss_evt       (miss_evt)
  );

  mc_param_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_push (buf_clear_push),
    .push       (buf_push),
    .push_data  (mth_data),
    .pop        (fetch_pop && busy),
    .count      (param_count),
    .first_word (first_param),
    .head_word  (fetch_data),
    .empty      (fetch_empty),
    .ovf_evt    (ovf_evt),
    .ovf_flag   (err_overflow)
  );

endmodule

// File: rtl/macro_collector_chk.sv
module macro_collector_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             exec_done,
  input logic [CNT_W-1:0] param_count,
  input logic             err_missing,
  input logic             err_overflow,
  input logic             miss_evt,
  input logic             ovf_evt
);

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && exec_done |=> !busy);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !exec_done |=> busy && $stable(param_count));

  p_start_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> param_count != '0);

  p_miss_nostart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> !start && err_missing && !busy);

  p_miss_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_missing |=> err_missing);

  p_ovf_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> err_overflow);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);

  p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    param_count <= CNT_W'(DEPTH));

endmodule

bind macro_collector macro_collector_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .exec_done    (exec_done),
  .param_count  (param_count),
  .err_missing  (err_missing),
  .err_overflow (err_overflow),
  .miss_evt     (miss_evt),
  .ovf_evt      (ovf_evt)
);

// File: tb/test_macro_collector.sv
module test_macro_collector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mth_valid = 1'b0;
  logic [11:0] mth_index = '0;
  logic [31:0] mth_data = '0;
  logic [7:0]  mth_remaining = '0;
  logic        upl_valid = 1'b0;
  logic [2:0]  upl_entry = '0;
  logic [9:0]  upl_base = '0;
  logic [9:0]  upl_len = '0;
  logic        fetch_pop = 1'b0;
  logic        exec_done = 1'b0;
  logic        start, busy, fetch_empty, err_missing, err_overflow;
  logic [9:0]  start_base, start_len;
  logic [31:0] first_param, fetch_data;
  logic [4:0]  param_count;

  always #4 clk = ~clk;

  macro_collector i_macro_collector (.*);

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit run = 0;

  // behavioural reference
  logic [31:0] q[$];
  int  m_rd, m_ent, off;
  bit  m_start, m_busy, m_coll, m_ok, m_miss, m_ovf;
  bit  t_valid [8];
  int  t_base [8];
  int  t_len [8];
  int  m_base, m_len;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_rd = 0; m_start = 0; m_busy = 0; m_coll = 0; m_ok = 0;
      m_miss = 0; m_ovf = 0; m_ent = 0;
      for (int i = 0; i < 8; i++) begin t_valid[i] = 0; t_base[i] = 0; t_len[i] = 0; end
    end else begin
      m_start = 0;
      if (!m_busy && mth_valid && mth_index >= 12'hE00) begin
        if (!m_coll) begin
          q.delete(); q.push_back(mth_data); m_rd = 1;
          off = int'(mth_index) - 'hE00;
          m_ok = (off % 2 == 0) && (off / 2 < 8);
          m_ent = off / 2;
        end else if (q.size() < 16) q.push_back(mth_data);
        else m_ovf = 1;
        if (mth_remaining == 0) begin
          m_coll = 0;
          if (m_ok && t_valid[m_ent]) begin
            m_start = 1; m_busy = 1; m_base = t_base[m_ent]; m_len = t_len[m_ent];
          end else m_miss = 1;
        end else m_coll = 1;
      end else if (m_busy) begin
        if (fetch_pop && m_rd < q.size()) m_rd++;
        if (exec_done) m_busy = 0;
      end
      if (upl_valid) begin
        t_valid[upl_entry] = 1; t_base[upl_entry] = upl_base; t_len[upl_entry] = upl_len;
      end
    end
  end

  always @(negedge clk) begin
    if (run) begin
      check("R4 start", 32'(start), 32'(m_start));
      check("R7 busy", 32'(busy), 32'(m_busy));
      check("R8 err_missing", 32'(err_missing), 32'(m_miss));
      check("R9 err_overflow", 32'(err_overflow), 32'(m_ovf));
      if (m_busy) begin
        check("R5 param_count", 32'(param_count), 32'(q.size()));
        check("R5 first_param", first_param, q[0]);
        check("R6 fetch_empty", 32'(fetch_empty), 32'(m_rd >= q.size()));
        if (m_rd < q.size()) check("R6 fetch_data", fetch_data, q[m_rd]);
      end
      if (m_start) begin
        check("R3 start_base", 32'(start_base), 32'(m_base));
        check("R3 start_len", 32'(start_len), 32'(m_len));
      end
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      report();
    end
  end

  task automatic mwr(input logic [11:0] idx, input logic [31:0] d, input logic [7:0] rem);
    mth_valid = 1; mth_index = idx; mth_data = d; mth_remaining = rem;
    @(negedge clk);
    mth_valid = 0;
  endtask

  task automatic upload(input int e, input int b, input int l);
    upl_valid = 1; upl_entry = 3'(e); upl_base = 10'(b); upl_len = 10'(l);
    @(negedge clk);
    upl_valid = 0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      fetch_pop = 1; @(negedge clk); fetch_pop = 0;
    end
  endtask

  task automatic done();
    exec_done = 1; @(negedge clk); exec_done = 0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 start", 32'(start), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 err_missing", 32'(err_missing), 0);
    check("R1 err_overflow", 32'(err_overflow), 0);
    check("R1 fetch_empty", 32'(fetch_empty), 1);
    run = 1;

    upload(0, 10, 5);
    upload(3, 100, 20);

    // R2: below the macro range
    mwr(12'h100, 32'hDEAD, 0);
    check("R2 low method no start", 32'(start), 0);
    check("R2 low method no busy", 32'(busy), 0);
    check("R2 low method no error", 32'(err_missing), 0);

    // R3/R4/R5/R6: three-word call to entry 0
    mwr(12'hE00, 32'h11, 2);
    mwr(12'hE00, 32'h22, 1);
    mwr(12'hE01, 32'h33, 0);
    check("R3 entry0 base", 32'(start_base), 10);
    @(negedge clk);
    // R7: writes while busy ignored
    mwr(12'hE06, 32'h99, 0);
    check("R7 busy write ignored", 32'(param_count), 3);
    pop_n(4);  // last pop is on empty (R6)
    check("R6 empty after pops", 32'(fetch_empty), 1);
    done();

    // single-word call to entry 3
    mwr(12'hE06, 32'hABCD, 0);
    check("R3 entry3 len", 32'(start_len), 20);
    pop_n(1);
    done();

    // R8: missing entry, odd offset, beyond table
    mwr(12'hE04, 32'h1, 1);
    mwr(12'hE04, 32'h2, 0);
    check("R8 no start on missing", 32'(start), 0);
    check("R8 flag set", 32'(err_missing), 1);
    mwr(12'hE07, 32'h5, 0);
    mwr(12'hE20, 32'h6, 0);
    check("R8 stays idle", 32'(busy), 0);

    // R9: 18 words
    for (int i = 0; i < 18; i++) mwr(12'hE00, 32'(32'h100 + i), 8'(17 - i));
    check("R9 count capped", 32'(param_count), 16);
    pop_n(5);
    done();

    // R10: re-upload entry 0
    upload(0, 200, 7);
    mwr(12'hE00, 32'h77, 1);
    mwr(12'hE00, 32'h78, 0);
    check("R10 new base", 32'(start_base), 200);
    check("R10 new len", 32'(start_len), 7);
    pop_n(2);
    done();

    repeat (3) @(negedge clk);
    report();
  end

endmodule